// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Decoder

This block is the clocked control front end of a synchronous burst SRAM, together with a small behavioural array of words. Each word is split into byte lanes. On every rising clock edge it samples two competing address strobes, three chip selects, a burst-advance input and a set of write enables. From these it decides what the next cycle is: a deselect, or a read or write that begins, continues or is suspended. Read data is not pipelined. The word at the registered address appears on the output during the same clock period in which that address was latched.

Bursts cover the two low address bits. A separate sequencer forms either a linear (wrapping add) or an interleaved (XOR) order from the start offset and a beat count. The data bus is split into an input word, an output word and an output-drive flag, so a pad ring or a bench can place the tri-state driver. Output enable is asynchronous. The drive flag follows it without a clock edge.

Top module: `fts_sram`

## Requirements
- R1: A synchronous active-high reset leaves the block deselected: during reset and on the edges after it, until a new start, `dout_en` is 0.
- R2: With `strobe_p_n` low and `sel_main_n` low, `sel_hi` high and `sel_lo_n` low, the address is loaded and a read begins. All write inputs are ignored on that edge and the array is left unchanged.
- R3: A controller start needs `strobe_c_n` low while the processor strobe is high or blocked. When both strobes are low with all selects active, the processor start wins and the cycle is a read even if writes are requested.
- R4: `sel_main_n` high blocks the processor strobe, which then counts as high. A running burst continues under `strobe_c_n` high. `strobe_c_n` low with `sel_main_n` high deselects.
- R5: A strobe that takes effect while `sel_hi` is low or `sel_lo_n` is high deselects the block, and `dout_en` is 0 in the following cycle.
- R6: Lane k covers data bits [9k+8:9k]. With `wr_all_n` low, every lane is written. Otherwise lane k is written when `wr_byte_n` is low and `lane_wr_n[k]` is low. With no lane selected, the cycle is a read.
- R7: On an edge with both strobes inactive during a burst, `adv_n` high keeps the current address (suspend).
- R8: With `adv_n` low the burst moves to its next beat k (k counts 1, 2, 3, 0…). The two low address bits become (start+k) mod 4 when `order_linear` is 1 and start XOR k when it is 0. The upper bits keep their value.
- R9: Continue and suspend edges sample the write enables, so a burst begun as a read can carry on as a write and the reverse.
- R10: `dout_en` is 1 only in a read cycle with `oe_n` low. In any write cycle it is 0 whatever `oe_n` is.
- R11: After the edge that sets a read address A, `dout` equals the word at A before the next edge.
- R12: While deselected, edges with no strobe leave the block deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | External word address |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| sel_main_n | input | 1 | Master chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| din | input | W | Write data |
| dout | output | W | Read data |
| dout_en | output | 1 | Output driver enable |

## Verification
The whole array is first filled through controller-started writes. Strobe patterns are then applied one after another: each strobe alone, both strobes together, the processor strobe with the master select blocked, and strobes with a secondary select inactive. Each outcome shows whether the edge counted as a start, a continue or a deselect. Bursts run in both orders from unaligned start offsets, which tells an XOR sequence from an add sequence. Suspend edges are mixed in to tell a hold from an advance. Lane-masked writes and mid-burst switches between read and write are read back word by word, which shows which lanes and which addresses each edge actually changed.

// File: rtl/fts_pkg.sv
package fts_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;

   localparam int BURST_BITS = 2;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
   parameter int BB = 2
) (
   input  logic [BB-1:0] origin,
   input  logic [BB-1:0] beat,
   input  logic          linear,
   output logic [BB-1:0] offs
);
   generate
      if (BB < 1) begin : g_bad_bb
         $error("fts_burst_seq: BB must be at least 1");
      end
   endgenerate

   // linear wraps inside the burst window, interleaved flips offset bits
   assign offs = linear ? (origin + beat) : (origin ^ beat);
endmodule

// File: rtl/fts_cycle_dec.sv
module fts_cycle_dec
   import fts_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe_p_n,
   input  logic             strobe_c_n,
   input  logic             sel_main_n,
   input  logic             sel_hi,
   input  logic             sel_lo_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             busy,
   output logic             load,
   output logic             step,
   output cyc_e             next_mode,
   output logic [LANES-1:0] lane_we
);
   logic             sec_ok;
   logic             p_live;
   logic             c_live;
   logic [LANES-1:0] lanes_req;
   logic             wr_req;

   assign sec_ok = sel_hi & ~sel_lo_n;
   // master select gates the processor strobe only
   assign p_live = ~strobe_p_n & ~sel_main_n;
   assign c_live = ~strobe_c_n & ~p_live;

   always_comb begin
      if (!wr_all_n)       lanes_req = '1;
      else if (!wr_byte_n) lanes_req = ~lane_wr_n;
      else                 lanes_req = '0;
   end
   assign wr_req = |lanes_req;

   always_comb begin
      load      = 1'b0;
      step      = 1'b0;
      next_mode = CYC_IDLE;
      lane_we   = '0;
      if (p_live) begin
         if (sec_ok) begin
            load      = 1'b1;
            next_mode = CYC_READ;
         end
      end else if (c_live) begin
         if (!sel_main_n && sec_ok) begin
            load      = 1'b1;
            next_mode = wr_req ? CYC_WRITE : CYC_READ;
            lane_we   = lanes_req;
         end
      end else if (busy) begin
         step      = ~adv_n;
         next_mode = wr_req ? CYC_WRITE : CYC_READ;
         lane_we   = lanes_req;
      end
   end

   assert_pstart_no_write_R2: assert property (@(posedge clk) disable iff (rst)
      (!strobe_p_n && !sel_main_n) |-> (lane_we == '0));

   assert_global_all_lanes_R6: assert property (@(posedge clk) disable iff (rst)
      (!wr_all_n && next_mode == CYC_WRITE) |-> (&lane_we));

   assert_idle_no_strobe_R12: assert property (@(posedge clk) disable iff (rst)
      (!busy && strobe_c_n && (strobe_p_n || sel_main_n)) |-> (next_mode == CYC_IDLE));
endmodule

// File: rtl/fts_mem.sv
module fts_mem #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                     clk,
   input  logic [LANES-1:0]         we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [LANES*LANE_W-1:0]  rdata
);
   localparam int W = LANES * LANE_W;

   logic [W-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (we[k]) arr[waddr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
   end

   assign rdata = arr[raddr];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
   import fts_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AW-1:0]    addr_in,
   input  logic             strobe_p_n,
   input  logic             strobe_c_n,
   input  logic             sel_main_n,
   input  logic             sel_hi,
   input  logic             sel_lo_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             oe_n,
   input  logic             order_linear,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic             dout_en
);
   localparam int BB = BURST_BITS;

   generate
      if (DEPTH < (1 << BB) || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fts_sram: DEPTH must be a power of two covering one burst");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("fts_sram: LANES and LANE_W must be positive");
      end
   endgenerate

   logic [AW-1:0]    base_q, nbase;
   logic [BB-1:0]    cnt_q, ncnt;
   cyc_e             mode_q, next_mode;
   logic             load, step;
   logic [LANES-1:0] lane_we;
   logic [BB-1:0]    cur_low, nxt_low;
   logic [AW-1:0]    rd_addr, wr_addr;

   fts_cycle_dec #(.LANES(LANES)) u_dec (
      .clk        (clk),
      .rst        (rst),
      .strobe_p_n (strobe_p_n),
      .strobe_c_n (strobe_c_n),
      .sel_main_n (sel_main_n),
      .sel_hi     (sel_hi),
      .sel_lo_n   (sel_lo_n),
      .adv_n      (adv_n),
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_wr_n  (lane_wr_n),
      .busy       (mode_q != CYC_IDLE),
      .load       (load),
      .step       (step),
      .next_mode  (next_mode),
      .lane_we    (lane_we)
   );

   assign nbase = load ? addr_in : base_q;
   assign ncnt  = load ? '0 : (step ? cnt_q + BB'(1) : cnt_q);

   fts_burst_seq #(.BB(BB)) u_seq_cur (
      .origin (base_q[BB-1:0]),
      .beat   (cnt_q),
      .linear (order_linear),
      .offs   (cur_low)
   );

   fts_burst_seq #(.BB(BB)) u_seq_nxt (
      .origin (nbase[BB-1:0]),
      .beat   (ncnt),
      .linear (order_linear),
      .offs   (nxt_low)
   );

   assign rd_addr = {base_q[AW-1:BB], cur_low};
   assign wr_addr = {nbase[AW-1:BB], nxt_low};

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= CYC_IDLE;
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         mode_q <= next_mode;
         base_q <= nbase;
         cnt_q  <= ncnt;
      end
   end

   fts_mem #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .we    (rst ? '0 : lane_we),
      .waddr (wr_addr),
      .wdata (din),
      .raddr (rd_addr),
      .rdata (dout)
   );

   assign dout_en = (mode_q == CYC_READ) & ~oe_n;

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> !dout_en);

   assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (((!strobe_p_n && !sel_main_n) || !strobe_c_n) && !(sel_hi && !sel_lo_n)) |=> !dout_en);

   assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
      (|lane_we) |=> !dout_en);

   assert_suspend_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_q != CYC_IDLE && strobe_c_n && (strobe_p_n || sel_main_n) && adv_n)
      |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: tb/test_fts_sram.sv
`timescale 1ns/1ps
module test_fts_sram;
   localparam int DEPTH = 256;
   localparam int AW    = 8;
   localparam int W     = 18;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic          strobe_p_n = 1'b1, strobe_c_n = 1'b1, sel_main_n = 1'b0;
   logic          sel_hi = 1'b1, sel_lo_n = 1'b0, adv_n = 1'b1;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [1:0]    lane_wr_n = 2'b11;
   logic          oe_n = 1'b1, order_linear = 1'b0;
   logic [W-1:0]  din = '0;
   logic [W-1:0]  dout;
   logic          dout_en;

   always #4 clk = ~clk;

   fts_sram i_fts_sram (
      .clk(clk), .rst(rst), .addr_in(addr_in),
      .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
      .sel_main_n(sel_main_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
      .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
      .lane_wr_n(lane_wr_n), .oe_n(oe_n), .order_linear(order_linear),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model
   logic [W-1:0]  ref_mem [DEPTH];
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt  = '0;
   int            m_mode = 0; // 0 idle, 1 read, 2 write

   // scoreboard queues
   logic          q_en   [$];
   logic [W-1:0]  q_data [$];
   string         q_tag  [$];

   function automatic logic [W-1:0] pat(input int a);
      return W'((a * 1237) ^ 18'h2A5C3);
   endfunction

   function automatic logic [AW-1:0] eff_addr(input logic [AW-1:0] b, input logic [1:0] c,
                                               input logic lin);
      logic [1:0] lo;
      lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
      return {b[AW-1:2], lo};
   endfunction

   task automatic go(input string tag, input logic r, input logic pn, input logic cn,
                     input logic mn, input logic hi, input logic lon, input logic an,
                     input logic gn, input logic bn, input logic [1:0] ln,
                     input logic oen, input logic [W-1:0] d, input logic [AW-1:0] a);
      logic [1:0]    lanes;
      logic          pl;
      logic          sok;
      logic [AW-1:0] ea;
      @(negedge clk);
      rst = r; strobe_p_n = pn; strobe_c_n = cn; sel_main_n = mn; sel_hi = hi;
      sel_lo_n = lon; adv_n = an; wr_all_n = gn; wr_byte_n = bn; lane_wr_n = ln;
      oe_n = oen; din = d; addr_in = a;
      lanes = !gn ? 2'b11 : (!bn ? ~ln : 2'b00);
      pl  = !pn && !mn;
      sok = hi && !lon;
      if (r) begin
         m_mode = 0; m_base = '0; m_cnt = '0; lanes = 2'b00;
      end else if (pl) begin
         lanes = 2'b00;
         if (sok) begin m_base = a; m_cnt = '0; m_mode = 1; end
         else m_mode = 0;
      end else if (!cn) begin
         if (!mn && sok) begin m_base = a; m_cnt = '0; m_mode = (lanes != 0) ? 2 : 1; end
         else begin m_mode = 0; lanes = 2'b00; end
      end else if (m_mode != 0) begin
         if (!an) m_cnt = m_cnt + 2'd1;
         m_mode = (lanes != 0) ? 2 : 1;
      end else begin
         lanes = 2'b00;
      end
      ea = eff_addr(m_base, m_cnt, order_linear);
      if (m_mode == 2) begin
         if (lanes[0]) ref_mem[ea][8:0]  = d[8:0];
         if (lanes[1]) ref_mem[ea][17:9] = d[17:9];
      end
      q_en.push_back((m_mode == 1) && !oen);
      q_data.push_back(ref_mem[ea]);
      q_tag.push_back(tag);
   endtask

   // common cycle shapes
   task automatic pstart(input string tag, input logic gn, input logic oen, input logic [AW-1:0] a);
      go(tag, 0, 0, 1, 0, 1, 0, 1, gn, 1, 2'b11, oen, '0, a);
   endtask
   task automatic cstart(input string tag, input logic gn, input logic bn, input logic [1:0] ln,
                         input logic oen, input logic [W-1:0] d, input logic [AW-1:0] a);
      go(tag, 0, 1, 0, 0, 1, 0, 1, gn, bn, ln, oen, d, a);
   endtask
   task automatic cont(input string tag, input logic an, input logic gn, input logic bn,
                       input logic [1:0] ln, input logic oen, input logic [W-1:0] d);
      go(tag, 0, 1, 1, 0, 1, 0, an, gn, bn, ln, oen, d, '0);
   endtask

   // monitor: compares each cycle's output against the queued expectation
   always @(posedge clk) begin
      #2;
      if (q_en.size() != 0) begin
         logic         e;
         logic [W-1:0] ed;
         string        t;
         e = q_en.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
         checks++;
         if (dout_en !== e) begin
            errors++;
            $display("FAIL %s dout_en actual %b expected %b", t, dout_en, e);
         end else if (e && dout !== ed) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h", t, dout, ed);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      // R1: reset state
      go("R1", 1, 1, 1, 0, 1, 0, 1, 1, 1, 2'b11, 0, '0, '0);
      go("R1", 1, 1, 1, 0, 1, 0, 1, 1, 1, 2'b11, 0, '0, '0);
      go("R1", 0, 1, 1, 0, 1, 0, 1, 1, 1, 2'b11, 0, '0, '0);
      // R6: fill the array with global writes
      for (int a = 0; a < DEPTH; a++) cstart("R6", 0, 1, 2'b11, 1, pat(a), AW'(a));
      // R5: secondary select off deselects; R12: stays idle
      go("R5", 0, 0, 1, 0, 0, 0, 1, 1, 1, 2'b11, 0, '0, 8'h00);
      go("R12", 0, 1, 1, 0, 1, 0, 0, 1, 1, 2'b11, 0, '0, '0);
      go("R5", 0, 1, 0, 0, 1, 1, 1, 1, 1, 2'b11, 0, '0, 8'h05);
      // R2 / R11: processor start reads with global write asserted
      pstart("R2", 0, 0, 8'h41);
      cont("R8", 0, 1, 1, 2'b11, 0, '0);
      cont("R8", 0, 1, 1, 2'b11, 0, '0);
      cont("R8", 0, 1, 1, 2'b11, 0, '0);
      cont("R7", 1, 1, 1, 2'b11, 0, '0);
      cont("R10", 1, 1, 1, 2'b11, 1, '0);
      // R8 linear order from unaligned start
      go("R5", 0, 1, 0, 0, 0, 0, 1, 1, 1, 2'b11, 0, '0, '0);
      order_linear = 1'b1;
      pstart("R11", 1, 0, 8'h86);
      cont("R8", 0, 1, 1, 2'b11, 0, '0);
      cont("R8", 0, 1, 1, 2'b11, 0, '0);
      cont("R8", 0, 1, 1, 2'b11, 0, '0);
      // R6 lane writes, R9 write-to-read change, R10 no drive on write
      cstart("R10", 1, 0, 2'b10, 0, 18'h3FFFF, 8'h10);
      cont("R6", 0, 1, 0, 2'b01, 0, 18'h00000);
      cont("R9", 0, 1, 1, 2'b00, 0, '0);
      cstart("R6", 1, 1, 2'b11, 0, '0, 8'h10);
      cstart("R6", 1, 1, 2'b11, 0, '0, 8'h11);
      cstart("R6", 1, 1, 2'b00, 0, 18'h15555, 8'h20);
      // R3: both strobes low, processor wins, no write
      go("R3", 0, 0, 0, 0, 1, 0, 1, 0, 1, 2'b11, 0, 18'h00BAD, 8'h30);
      cstart("R3", 1, 1, 2'b11, 0, '0, 8'h30);
      // R4: master select blocks processor strobe
      pstart("R4", 1, 0, 8'h50);
      go("R4", 0, 0, 1, 1, 1, 0, 0, 1, 1, 2'b11, 0, '0, 8'h99);
      go("R4", 0, 1, 0, 1, 1, 0, 1, 1, 1, 2'b11, 0, '0, 8'h50);
      go("R12", 0, 0, 1, 1, 1, 0, 0, 1, 1, 2'b11, 0, '0, 8'h50);
      // R2: word read under processor start stays intact
      cstart("R2", 1, 1, 2'b11, 0, '0, 8'h41);
      // R9: read burst turns into write, then suspend reads it back
      cstart("R9", 1, 1, 2'b11, 0, '0, 8'h60);
      cont("R9", 0, 0, 1, 2'b11, 0, 18'h12345);
      cont("R7", 1, 1, 1, 2'b11, 0, '0);
      // R1: reset in the middle of a burst
      go("R1", 1, 1, 1, 0, 1, 0, 1, 1, 1, 2'b11, 0, '0, '0);
      go("R1", 0, 1, 1, 0, 1, 0, 0, 1, 1, 2'b11, 0, '0, '0);
      @(posedge clk);
      #3;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule